// File: doc/BRIEF.md
# I2C SCL Clock Waveform Generator

This block produces the SCL clock for an I2C master, running from the peripheral clock. It drives the line low for the low phase and releases it for the high phase. It also emits a one-cycle strobe at each SCL edge, and a strobe that marks the point where SDA may change after SCL falls. Start/stop generation, byte shifting and arbitration belong to neighbouring logic, which uses these strobes as timing references.

All timing comes from one configuration word. A 3-bit exponent scales two 8-bit dividers, one for the low phase and one for the high phase, and a fixed offset is added. Each phase therefore lasts `div * 2^exp + OFFSET` peripheral cycles. A hold count sets how late the SDA change point falls within the low phase.

If the exponent is above the supported maximum, the generator clamps it and uses the largest divider. A request for a rate that is too slow therefore gives the slowest clock, not a wrapped one. A hold count above its maximum is clamped in the same way.

The word is sampled only when a low phase starts. A slave that stretches the clock, holding SCL low while the block has released it, pauses the high phase.

Top module: `scl_wave_gen`

## Requirements
- R1: After reset, `scl_drive_low` is 0 and `scl_rise`, `scl_fall` and `sda_change` are all 0.
- R2: The low phase lasts `lo * 2^exp + OFFSET` cycles, counted from the `scl_fall` strobe to the `scl_rise` strobe. Here `exp` is `cfg_word[18:16]` and `lo` is `cfg_word[7:0]`.
- R3: The high phase lasts `hi * 2^exp + OFFSET` cycles, counted from the `scl_rise` strobe to the next `scl_fall` strobe, while `scl_in` stays high. Here `hi` is `cfg_word[15:8]`.
- R4: An exponent above `EXP_MAX` is treated as `EXP_MAX`, and both dividers are then treated as 255.
- R5: While the block has released SCL but `scl_in` is low, the high phase does not end, and its count restarts from full length. The high phase therefore lasts the stretched cycles plus `hi * 2^exp + OFFSET`.
- R6: `sda_change` pulses `hold + 3` cycles after the `scl_fall` strobe. Here `hold` is `cfg_word[19 +: HOLD_W]`.
- R7: A hold field above `HOLD_MAX` is treated as `HOLD_MAX`.
- R8: `cfg_word` is sampled only in the cycle a low phase begins. A change made during a low phase alters neither that low phase nor the high phase that follows it.
- R9: While `en` is 0, SCL is released in the next cycle and no strobe fires. When `en` goes to 1, the generator starts with a low phase, and `scl_fall` rises in the cycle after `en` is first sampled high.
- R10: `scl_rise` and `scl_fall` are single-cycle pulses and never fire together. `scl_fall` coincides with `scl_drive_low` going to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; when low, SCL is released |
| cfg_word | input | 19+HOLD_W | Hold count [19 +: HOLD_W], exponent [18:16], high divider [15:8], low divider [7:0] |
| scl_in | input | 1 | Sampled SCL line level |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| scl_rise | output | 1 | Strobe in the first cycle of a high phase |
| scl_fall | output | 1 | Strobe in the first cycle of a low phase |
| sda_change | output | 1 | Strobe marking when SDA may change |

## Verification
The bench uses the default parameters: OFFSET 4, EXP_MAX 5, HOLD_W 6 and HOLD_MAX 40. With EXP_MAX at 5, an exponent field of 7 is legal in the word but out of range, so the exponent clamp and the forced 255 divider can be reached. Under these values a saturated phase lasts 8164 cycles, which keeps the test short. Because the hold field is 6 bits wide and HOLD_MAX is 40, a hold of 63 exercises the hold clamp. Short dividers with exponents 0 and 2 make phase lengths, clock stretching and the configuration sampling point cheap to measure exactly.

// File: rtl/scl_wave_gen.sv
module scl_wave_gen #(
  parameter int OFFSET   = 4,
  parameter int EXP_MAX  = 5,
  parameter int HOLD_W   = 6,
  parameter int HOLD_MAX = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [18+HOLD_W:0] cfg_word,
  input  logic              scl_in,
  output logic              scl_drive_low,
  output logic              scl_rise,
  output logic              scl_fall,
  output logic              sda_change
);
  localparam int MAX_LEN = 255 * (2 ** EXP_MAX) + OFFSET;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam int HC_W    = HOLD_W + 1;

  logic              run_q, low_q, rise_q, fall_q, sda_q, hact_q;
  logic [CNT_W-1:0]  cnt_q, hi_len_q, lo_len, hi_len;
  logic [HC_W-1:0]   hcnt_q, hold_q;
  logic [2:0]        exp_raw, exp_eff;
  logic              sat;
  logic [7:0]        lo_div, hi_div;
  logic [HOLD_W-1:0] hold_raw, hold_eff;
  logic              enter_low;

  assign exp_raw  = cfg_word[18:16];
  assign sat      = exp_raw > 3'(EXP_MAX);
  assign exp_eff  = sat ? 3'(EXP_MAX) : exp_raw;
  assign lo_div   = sat ? 8'hFF : cfg_word[7:0];
  assign hi_div   = sat ? 8'hFF : cfg_word[15:8];
  assign lo_len   = (CNT_W'(lo_div) << exp_eff) + CNT_W'(OFFSET);
  assign hi_len   = (CNT_W'(hi_div) << exp_eff) + CNT_W'(OFFSET);
  assign hold_raw = cfg_word[19 +: HOLD_W];
  assign hold_eff = (hold_raw > HOLD_W'(HOLD_MAX)) ? HOLD_W'(HOLD_MAX) : hold_raw;
  assign hold_q   = {1'b0, hold_eff} + HC_W'(2);

  assign enter_low = !run_q || (!low_q && cnt_q == '0 && scl_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; low_q <= 1'b0; cnt_q <= '0; hi_len_q <= '0;
      rise_q <= 1'b0; fall_q <= 1'b0; sda_q <= 1'b0;
      hact_q <= 1'b0; hcnt_q <= '0;
    end else begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      sda_q  <= 1'b0;
      if (!en) begin
        run_q <= 1'b0; low_q <= 1'b0; cnt_q <= '0;
        hact_q <= 1'b0; hcnt_q <= '0;
      end else if (enter_low) begin
        run_q    <= 1'b1;
        low_q    <= 1'b1;
        fall_q   <= 1'b1;
        cnt_q    <= lo_len - CNT_W'(1);
        hi_len_q <= hi_len;
        hcnt_q   <= hold_q;
        hact_q   <= 1'b1;
      end else begin
        if (low_q) begin
          if (cnt_q == '0) begin
            low_q  <= 1'b0;
            rise_q <= 1'b1;
            cnt_q  <= hi_len_q - CNT_W'(1);
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end else if (!scl_in) begin
          cnt_q <= hi_len_q - CNT_W'(1);
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
        if (hact_q) begin
          if (hcnt_q == '0) begin
            sda_q  <= 1'b1;
            hact_q <= 1'b0;
          end else begin
            hcnt_q <= hcnt_q - HC_W'(1);
          end
        end
      end
    end
  end

  assign scl_drive_low = low_q;
  assign scl_rise      = rise_q;
  assign scl_fall      = fall_q;
  assign sda_change    = sda_q;

  assert_stretch_holds_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !low_q && !scl_in) |=> !scl_drive_low);
  assert_disable_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_drive_low && !scl_rise && !scl_fall));
  assert_edges_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_rise, scl_fall}));
  assert_fall_pulls_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall |-> (scl_drive_low && !$past(scl_drive_low)));
  assert_rise_releases_R3: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise |-> (!scl_drive_low && $past(scl_drive_low)));
endmodule

// File: tb/scl_wave_gen_bench.sv
module scl_wave_gen_bench;
  localparam int CLK_P  = 10;
  localparam int HOLD_W = 6;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, stretch = 1'b0;
  logic [18+HOLD_W:0] cfg_word = '0;
  logic scl_in, scl_drive_low, scl_rise, scl_fall, sda_change;
  int errors = 0, checks = 0;

  always #(CLK_P/2) clk = ~clk;
  assign scl_in = ~scl_drive_low & ~stretch;

  scl_wave_gen u_scl_wave_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_word(cfg_word), .scl_in(scl_in),
    .scl_drive_low(scl_drive_low), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_change(sda_change));

  function automatic logic [18+HOLD_W:0] mk(int e, int hi, int lo, int hold);
    return {HOLD_W'(hold), 3'(e), 8'(hi), 8'(lo)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_fall(); while (!scl_fall) @(negedge clk); endtask
  task automatic wait_rise(); while (!scl_rise) @(negedge clk); endtask

  task automatic meas_low(output int n);
    wait_fall();
    n = 0;
    do begin n++; @(negedge clk); end while (!scl_rise);
  endtask

  task automatic meas_high(output int n);
    wait_rise();
    n = 0;
    do begin n++; @(negedge clk); end while (!scl_fall);
  endtask

  task automatic meas_hold(output int n);
    wait_fall();
    n = 0;
    do begin @(negedge clk); n++; end while (!sda_change);
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(!scl_drive_low && !scl_rise && !scl_fall && !sda_change, "R1 reset state",
        {scl_drive_low, scl_rise, scl_fall, sda_change}, 0);
  endtask

  task automatic test_phases();
    int n;
    cfg_word = mk(0, 3, 2, 5);
    en = 1'b1;
    @(negedge clk);
    chk(scl_fall && scl_drive_low, "R9 start with low phase", scl_fall, 1);
    meas_low(n);  chk(n == 6, "R2 low exp0 lo2", n, 6);
    meas_high(n); chk(n == 7, "R3 high exp0 hi3", n, 7);
    cfg_word = mk(2, 0, 1, 5);
    meas_low(n);  meas_low(n); chk(n == 8, "R2 low exp2 lo1", n, 8);
    meas_high(n); chk(n == 4, "R3 high exp2 hi0", n, 4);
  endtask

  task automatic test_strobes();
    cfg_word = mk(0, 3, 2, 5);
    wait_rise();
    chk(!scl_fall && !scl_drive_low, "R10 rise alone", scl_fall, 0);
    @(negedge clk);
    chk(!scl_rise, "R10 rise one cycle", scl_rise, 0);
    wait_fall();
    chk(!scl_rise && scl_drive_low, "R10 fall alone", scl_rise, 0);
    @(negedge clk);
    chk(!scl_fall, "R10 fall one cycle", scl_fall, 0);
  endtask

  task automatic test_hold();
    int n;
    cfg_word = mk(0, 20, 20, 5);
    meas_hold(n); meas_hold(n); chk(n == 8, "R6 hold 5", n, 8);
    cfg_word = mk(0, 20, 20, 0);
    meas_hold(n); meas_hold(n); chk(n == 3, "R6 hold 0", n, 3);
    cfg_word = mk(0, 30, 30, 63);
    meas_hold(n); meas_hold(n); chk(n == 43, "R7 hold clamped", n, 43);
  endtask

  task automatic test_saturate();
    int n;
    cfg_word = mk(7, 1, 1, 0);
    meas_low(n); meas_low(n); chk(n == 8164, "R4 low saturated", n, 8164);
    meas_high(n); chk(n == 8164, "R4 high saturated", n, 8164);
    cfg_word = mk(0, 3, 2, 0);
    meas_low(n); meas_low(n); chk(n == 6, "R4 recovers", n, 6);
  endtask

  task automatic test_stretch();
    int n;
    bit fell = 0;
    cfg_word = mk(0, 3, 2, 0);
    wait_rise();
    stretch = 1'b1;
    n = 0;
    repeat (10) begin @(negedge clk); n++; if (scl_fall || scl_drive_low) fell = 1; end
    stretch = 1'b0;
    chk(!fell, "R5 no low while stretched", fell, 0);
    while (!scl_fall) begin @(negedge clk); n++; end
    chk(n == 17, "R5 stretched high length", n, 17);
  endtask

  task automatic test_cfg_sample();
    int n;
    cfg_word = mk(0, 3, 2, 0);
    wait_rise();
    wait_fall();
    cfg_word = mk(0, 9, 9, 0);
    n = 0;
    do begin n++; @(negedge clk); end while (!scl_rise);
    chk(n == 6, "R8 current low unchanged", n, 6);
    meas_high(n); chk(n == 7, "R8 following high unchanged", n, 7);
    meas_low(n);  chk(n == 13, "R8 new low applied", n, 13);
  endtask

  task automatic test_disable();
    bit seen = 0;
    cfg_word = mk(0, 3, 2, 0);
    wait_fall();
    en = 1'b0;
    @(negedge clk);
    chk(!scl_drive_low, "R9 released after disable", scl_drive_low, 0);
    repeat (20) begin
      @(negedge clk);
      if (scl_drive_low || scl_rise || scl_fall || sda_change) seen = 1;
    end
    chk(!seen, "R9 quiet while disabled", seen, 0);
    en = 1'b1;
    @(negedge clk);
    chk(scl_fall && scl_drive_low, "R9 restart low", scl_fall, 1);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    test_reset();
    test_phases();
    test_strobes();
    test_hold();
    test_saturate();
    test_stretch();
    test_cfg_sample();
    test_disable();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule